// File: doc/BRIEF.md
# Codec Control-Slot Decoder and Readback Scheduler

This block sits on the codec side of a time-slotted serial link. Each sample frame is divided into slots. The host places a 16-bit control word in the control slot. The block captures that word, and a control word that is not a read request writes its data byte into a small indexed register file. Three entries of that file are protected. A write to one of them takes effect only when the same word carries the mode-change flag. While the flag is held, the block mutes the DAC.

For every outgoing status slot the block chooses between two words. One is a status word that carries per-channel overrange codes. The other is the contents of a register the host asked to read back. Which slot carries status depends on a slot-select mode that is latched at each sample boundary. When that mode changes, a read request can be answered twice or not at all, in defined ways. Overrange codes either follow each sample or hold the largest value seen. The choice is made by a clear-overrange flag, and a change to that flag reaches the status after a delay of one sample.

Top module: `cw_slot_ctrl`

## Requirements
- R1: After reset the control register holds 16'hC000, so `dac_mute` is 1, the overrange status is zero, the slot-select mode is 0 and no read request is pending.
- R2: A received word is taken as a control word only when `rx_vld` is high and `rx_slot` equals 0. Words in any other slot change neither the register file nor `dac_mute`.
- R3: A control word with bit 13 (read request) at 0 writes bits 7:0 into the entry chosen by bits 11:8. Entries 13 to 15 are not implemented: writes to them are dropped and they read back as 8'h00.
- R4: Entries 8 and 12 ignore writes whose bit 14 (mode-change) is 0. In entry 9, bit 3 keeps its old value under such a write while the other bits are written.
- R5: `dac_mute` equals bit 14 of the most recently captured control word.
- R6: A `tx_stb` whose `tx_slot` is the status slot gives `tx_vld` for exactly one cycle on the following cycle. The status slot is slot 3 when the mode latched at the last sample boundary is 0, and slot 0 when that mode is 1. Any other slot gives no `tx_vld`.
- R7: A status answer has `tx_rb` = 0 and word {12'h000, right[1:0], left[1:0]}. Left is `ovr_in[1:0]` and right is `ovr_in[3:2]`.
- R8: In mode 0, a read request captured in a frame is answered in slot 3 of that same frame. The answer has `tx_rb` = 1 and the word {control word bits 15:8, register contents}.
- R9: In mode 1, a read request is answered only in slot 0 of the next frame. The answer uses the control byte and register contents held at the boundary, and it is sent once.
- R10: When the mode goes from 0 to 1 at the boundary that follows a request, the readback is sent in slot 3 of the current frame and again in slot 0 of the next frame.
- R11: When the mode goes from 1 to 0 at the boundary that follows a request, the request is dropped. Neither slot returns it.
- R12: Within one frame, the last control word captured decides whether a read request is pending and which index it names.
- R13: At each sample boundary, with the clear flag in effect, each overrange field takes the sampled input. Without it, each field keeps the larger (unsigned) of its held value and the input.
- R14: The clear flag applied at a boundary is the control word's bit 15 as held at the previous boundary. A change to bit 15 therefore takes effect at the second boundary after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_vld | input | 1 | A received slot word is present |
| rx_slot | input | 2 | Slot number of the received word |
| rx_word | input | 16 | Received slot word |
| frame_stb | input | 1 | Sample boundary strobe |
| slot_sel | input | 1 | Slot-select mode, latched at each boundary |
| ovr_in | input | 4 | Overrange codes for this sample: left [1:0], right [3:2] |
| tx_stb | input | 1 | Request for the outgoing word of a slot |
| tx_slot | input | 2 | Slot number of that request |
| tx_vld | output | 1 | Outgoing word is valid (status slot only) |
| tx_word | output | 16 | Outgoing status or readback word |
| tx_rb | output | 1 | Outgoing word is a readback |
| dac_mute | output | 1 | DAC mute while mode-change is held |

## Verification
The bench changes the slot-select mode around pending requests. A scheduler that read the live mode input, rather than the latched one, would drop the second copy in the 0-to-1 case or leak a stale answer in the 1-to-0 case. The bench also writes the protected entries with the mode-change flag cleared. A design that gated on the flag held in the control register, or that masked the whole of entry 9, would return the new value, or would lose the bits that must still change. The bench sends words in slots other than the control slot, reads back unimplemented indices, and checks that a second word in the same frame replaces a pending request. Overrange checks go through the sticky and live modes and count the boundaries after the clear flag is flipped. A design with no delay, or with too much, would report the wrong code at the first or the second boundary.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int CW_W      = 16;
  localparam int CW_IDX_W  = 4;
  localparam int CW_DATA_W = 8;

  // Bit order is fixed: the host encodes these fields.
  typedef struct packed {
    logic                 clor;
    logic                 mce;
    logic                 rreq;
    logic                 rsvd;
    logic [CW_IDX_W-1:0]  idx;
    logic [CW_DATA_W-1:0] data;
  } cw_t;

  localparam logic [CW_W-1:0] CW_RESET = 16'hC000;
endpackage

// File: rtl/cw_regfile.sv
module cw_regfile #(
  parameter int IDX_W    = 4,
  parameter int DATA_W   = 8,
  parameter logic [(2**IDX_W)-1:0] IMPL_MASK = 16'h1FFF,
  parameter int FMT_IDX  = 8,
  parameter int MISC_IDX = 12,
  parameter int CFG_IDX  = 9,
  parameter int CAL_BIT  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_unlock,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 2**IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] wr_val;
  logic              full_lock;

  // Whole-entry locks, and a single locked bit in the configuration entry.
  assign full_lock = !wr_unlock &&
                     (wr_idx == IDX_W'(FMT_IDX) || wr_idx == IDX_W'(MISC_IDX));

  always_comb begin
    wr_val = wr_data;
    if (!wr_unlock && wr_idx == IDX_W'(CFG_IDX))
      wr_val[CAL_BIT] = mem[CFG_IDX][CAL_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && IMPL_MASK[wr_idx] && !full_lock) begin
      mem[wr_idx] <= wr_val;
    end
  end

  assign rd_data = IMPL_MASK[rd_idx] ? mem[rd_idx] : '0;
endmodule

// File: rtl/cw_ovr.sv
module cw_ovr #(
  parameter int NUM_CH = 2,
  parameter int OVR_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_stb,
  input  logic                     clor,
  input  logic [NUM_CH*OVR_W-1:0]  ovr_in,
  output logic [NUM_CH*OVR_W-1:0]  ovr_st
);
  logic clor_d;

  // One boundary of delay on the clear flag.
  always_ff @(posedge clk) begin
    if (rst)          clor_d <= 1'b1;
    else if (smp_stb) clor_d <= clor;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [OVR_W-1:0] cur;
    logic [OVR_W-1:0] held;
    assign cur  = ovr_in[ch*OVR_W +: OVR_W];
    assign held = ovr_st[ch*OVR_W +: OVR_W];
    always_ff @(posedge clk) begin
      if (rst)
        ovr_st[ch*OVR_W +: OVR_W] <= '0;
      else if (smp_stb && (clor_d || cur > held))
        ovr_st[ch*OVR_W +: OVR_W] <= cur;
    end
  end
endmodule

// File: rtl/cw_rb_sched.sv
module cw_rb_sched #(
  parameter int W       = 16,
  parameter int SLOT_W  = 2,
  parameter int M0_SLOT = 3,
  parameter int M1_SLOT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic              slot_sel,
  input  logic              cap_en,
  input  logic              cap_rreq,
  input  logic [W-1:0]      live_rb,
  input  logic [W-1:0]      status_word,
  input  logic              tx_stb,
  input  logic [SLOT_W-1:0] tx_slot,
  output logic              tx_vld,
  output logic [W-1:0]      tx_word,
  output logic              tx_rb
);
  logic              mode_q;
  logic              req_q;
  logic              req_prev;
  logic [W-1:0]      snap;
  logic [SLOT_W-1:0] stat_slot;

  assign stat_slot = mode_q ? SLOT_W'(M1_SLOT) : SLOT_W'(M0_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 1'b0;
      req_q    <= 1'b0;
      req_prev <= 1'b0;
      snap     <= '0;
      tx_vld   <= 1'b0;
      tx_word  <= '0;
      tx_rb    <= 1'b0;
    end else begin
      if (frame_stb) begin
        mode_q   <= slot_sel;
        req_prev <= req_q;
        snap     <= live_rb;
        req_q    <= 1'b0;
      end
      // A capture belongs to the frame that is open; the last one wins.
      if (cap_en) req_q <= cap_rreq;

      tx_vld <= 1'b0;
      tx_rb  <= 1'b0;
      if (tx_stb && tx_slot == stat_slot) begin
        tx_vld <= 1'b1;
        if (!mode_q && req_q) begin
          tx_word <= live_rb;
          tx_rb   <= 1'b1;
        end else if (mode_q && req_prev) begin
          tx_word <= snap;
          tx_rb   <= 1'b1;
        end else begin
          tx_word <= status_word;
        end
      end
    end
  end
endmodule

// File: rtl/cw_slot_ctrl.sv
module cw_slot_ctrl
  import cw_pkg::*;
#(
  parameter int SLOT_W    = 2,
  parameter int CTRL_SLOT = 0,
  parameter int M0_SLOT   = 3,
  parameter int M1_SLOT   = 0,
  parameter int NUM_CH    = 2,
  parameter int OVR_W     = 2,
  localparam int OVR_BITS = NUM_CH * OVR_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_vld,
  input  logic [SLOT_W-1:0]   rx_slot,
  input  logic [CW_W-1:0]     rx_word,
  input  logic                frame_stb,
  input  logic                slot_sel,
  input  logic [OVR_BITS-1:0] ovr_in,
  input  logic                tx_stb,
  input  logic [SLOT_W-1:0]   tx_slot,
  output logic                tx_vld,
  output logic [CW_W-1:0]     tx_word,
  output logic                tx_rb,
  output logic                dac_mute
);
  cw_t                  ctrl_q;
  cw_t                  rx_cw;
  logic                 cap;
  logic [CW_DATA_W-1:0] rd_data;
  logic [OVR_BITS-1:0]  ovr_st;
  logic [CW_W-1:0]      live_rb;
  logic [CW_W-1:0]      status_word;

  assign rx_cw = cw_t'(rx_word);
  assign cap   = rx_vld && rx_slot == SLOT_W'(CTRL_SLOT);

  always_ff @(posedge clk) begin
    if (rst)      ctrl_q <= cw_t'(CW_RESET);
    else if (cap) ctrl_q <= rx_cw;
  end

  assign dac_mute = ctrl_q.mce;

  cw_regfile #(
    .IDX_W (CW_IDX_W),
    .DATA_W(CW_DATA_W)
  ) u_rf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cap && !rx_cw.rreq),
    .wr_idx   (rx_cw.idx),
    .wr_data  (rx_cw.data),
    .wr_unlock(rx_cw.mce),
    .rd_idx   (ctrl_q.idx),
    .rd_data  (rd_data)
  );

  cw_ovr #(
    .NUM_CH(NUM_CH),
    .OVR_W (OVR_W)
  ) u_ovr (
    .clk    (clk),
    .rst    (rst),
    .smp_stb(frame_stb),
    .clor   (ctrl_q.clor),
    .ovr_in (ovr_in),
    .ovr_st (ovr_st)
  );

  assign live_rb     = {ctrl_q.clor, ctrl_q.mce, ctrl_q.rreq, ctrl_q.rsvd,
                        ctrl_q.idx, rd_data};
  assign status_word = {{(CW_W-OVR_BITS){1'b0}}, ovr_st};

  cw_rb_sched #(
    .W      (CW_W),
    .SLOT_W (SLOT_W),
    .M0_SLOT(M0_SLOT),
    .M1_SLOT(M1_SLOT)
  ) u_sched (
    .clk        (clk),
    .rst        (rst),
    .frame_stb  (frame_stb),
    .slot_sel   (slot_sel),
    .cap_en     (cap),
    .cap_rreq   (rx_cw.rreq),
    .live_rb    (live_rb),
    .status_word(status_word),
    .tx_stb     (tx_stb),
    .tx_slot    (tx_slot),
    .tx_vld     (tx_vld),
    .tx_word    (tx_word),
    .tx_rb      (tx_rb)
  );
endmodule

// File: rtl/cw_slot_ctrl_chk.sv
module cw_slot_ctrl_chk #(
  parameter int SLOT_W    = 2,
  parameter int CTRL_SLOT = 0,
  parameter int M0_SLOT   = 3,
  parameter int M1_SLOT   = 0,
  parameter int STAT_W    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_vld,
  input logic [SLOT_W-1:0] rx_slot,
  input logic [15:0]       rx_word,
  input logic              tx_stb,
  input logic [SLOT_W-1:0] tx_slot,
  input logic              tx_vld,
  input logic [15:0]       tx_word,
  input logic              tx_rb,
  input logic              dac_mute
);
  // R2
  ctrl_slot_only_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_vld && rx_slot != SLOT_W'(CTRL_SLOT)) |=> $stable(dac_mute));

  // R5
  mute_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_vld && rx_slot == SLOT_W'(CTRL_SLOT)) |=> (dac_mute == $past(rx_word[14])));

  // R6
  tx_src_chk: assert property (@(posedge clk) disable iff (rst)
    tx_vld |-> $past(tx_stb));

  // R6
  tx_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_stb && tx_slot != SLOT_W'(M0_SLOT) && tx_slot != SLOT_W'(M1_SLOT)) |=> !tx_vld);

  // R7
  status_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_vld && !tx_rb) |-> (tx_word[15:STAT_W] == '0));

  // R8
  rb_qual_chk: assert property (@(posedge clk) disable iff (rst)
    tx_rb |-> tx_vld);
endmodule

bind cw_slot_ctrl cw_slot_ctrl_chk #(
  .SLOT_W   (SLOT_W),
  .CTRL_SLOT(CTRL_SLOT),
  .M0_SLOT  (M0_SLOT),
  .M1_SLOT  (M1_SLOT),
  .STAT_W   (OVR_BITS)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rx_vld  (rx_vld),
  .rx_slot (rx_slot),
  .rx_word (rx_word),
  .tx_stb  (tx_stb),
  .tx_slot (tx_slot),
  .tx_vld  (tx_vld),
  .tx_word (tx_word),
  .tx_rb   (tx_rb),
  .dac_mute(dac_mute)
);

// File: tb/sim_cw_slot_ctrl.sv
module sim_cw_slot_ctrl;
  localparam int PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_vld = 1'b0;
  logic [1:0]  rx_slot = '0;
  logic [15:0] rx_word = '0;
  logic        frame_stb = 1'b0;
  logic        slot_sel = 1'b0;
  logic [3:0]  ovr_in = '0;
  logic        tx_stb = 1'b0;
  logic [1:0]  tx_slot = '0;
  logic        tx_vld;
  logic [15:0] tx_word;
  logic        tx_rb;
  logic        dac_mute;

  int n_chk = 0;
  int n_bad = 0;
  logic        q_vld;
  logic [15:0] q_word;
  logic        q_rb;

  always #(PERIOD/2) clk = ~clk;

  cw_slot_ctrl u0 (
    .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_slot(rx_slot), .rx_word(rx_word),
    .frame_stb(frame_stb), .slot_sel(slot_sel), .ovr_in(ovr_in),
    .tx_stb(tx_stb), .tx_slot(tx_slot), .tx_vld(tx_vld), .tx_word(tx_word),
    .tx_rb(tx_rb), .dac_mute(dac_mute)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_slot(input logic [1:0] s, input logic [15:0] w);
    @(negedge clk); rx_vld = 1'b1; rx_slot = s; rx_word = w;
    @(negedge clk); rx_vld = 1'b0;
  endtask

  task automatic send_cw(input logic [15:0] w);
    send_slot(2'd0, w);
  endtask

  task automatic boundary();
    @(negedge clk); frame_stb = 1'b1;
    @(negedge clk); frame_stb = 1'b0;
  endtask

  task automatic query(input logic [1:0] s);
    @(negedge clk); tx_stb = 1'b1; tx_slot = s;
    @(negedge clk); tx_stb = 1'b0;
    q_vld = tx_vld; q_word = tx_word; q_rb = tx_rb;
  endtask

  task automatic expect_rb(input string tag, input logic [1:0] s, input logic [15:0] w);
    query(s);
    check({tag, " vld"}, 32'(q_vld), 32'd1);
    check({tag, " rb"}, 32'(q_rb), 32'd1);
    check({tag, " word"}, 32'(q_word), 32'(w));
  endtask

  task automatic expect_status(input string tag, input logic [1:0] s, input logic [15:0] w);
    query(s);
    check({tag, " vld"}, 32'(q_vld), 32'd1);
    check({tag, " rb"}, 32'(q_rb), 32'd0);
    check({tag, " word"}, 32'(q_word), 32'(w));
  endtask

  task automatic expect_silent(input string tag, input logic [1:0] s);
    query(s);
    check({tag, " vld"}, 32'(q_vld), 32'd0);
  endtask

  task automatic t_reset();
    check("R1 mute after reset", 32'(dac_mute), 32'd1);
    expect_status("R1 status slot3 after reset", 2'd3, 16'h0000);
    expect_silent("R6 slot0 in mode 0", 2'd0);
    expect_silent("R6 slot1 never", 2'd1);
  endtask

  task automatic t_write_read();
    send_cw(16'h4155);
    send_cw(16'h6100);
    expect_rb("R8 R3 read idx1", 2'd3, 16'h6155);
    boundary();
    send_cw(16'h0D77);
    send_cw(16'h2D00);
    expect_rb("R3 unimplemented idx13", 2'd3, 16'h2D00);
    boundary();
  endtask

  task automatic t_slot_filter();
    send_cw(16'h4000);
    send_slot(2'd1, 16'h0000);
    check("R2 mute kept after slot1 word", 32'(dac_mute), 32'd1);
    send_slot(2'd2, 16'h0133);
    send_cw(16'h2100);
    expect_rb("R2 idx1 unchanged by slot2 word", 2'd3, 16'h2155);
    boundary();
  endtask

  task automatic t_protect();
    send_cw(16'h48AA);
    send_cw(16'h49FF);
    send_cw(16'h0811);
    check("R5 mute clears with flag 0", 32'(dac_mute), 32'd0);
    send_cw(16'h0900);
    send_cw(16'h0C33);
    send_cw(16'h2800);
    expect_rb("R4 idx8 locked", 2'd3, 16'h28AA);
    boundary();
    send_cw(16'h2900);
    expect_rb("R4 idx9 cal bit kept", 2'd3, 16'h2908);
    boundary();
    send_cw(16'h2C00);
    expect_rb("R4 idx12 locked", 2'd3, 16'h2C00);
    boundary();
    send_cw(16'h6800);
    check("R5 mute sets with flag 1", 32'(dac_mute), 32'd1);
    expect_rb("R8 flags in upper byte", 2'd3, 16'h68AA);
    boundary();
  endtask

  task automatic t_mode1();
    slot_sel = 1'b1;
    boundary();
    send_cw(16'h2100);
    expect_silent("R6 slot3 in mode 1", 2'd3);
    expect_status("R9 not answered in same frame", 2'd0, 16'h0000);
    boundary();
    expect_rb("R9 answered next frame slot0", 2'd0, 16'h2155);
    boundary();
    expect_status("R9 sent once", 2'd0, 16'h0000);
  endtask

  task automatic t_double();
    slot_sel = 1'b0;
    boundary();
    send_cw(16'h2100);
    slot_sel = 1'b1;
    expect_rb("R10 first copy slot3", 2'd3, 16'h2155);
    boundary();
    expect_rb("R10 second copy slot0", 2'd0, 16'h2155);
    boundary();
  endtask

  task automatic t_lost();
    send_cw(16'h2100);
    slot_sel = 1'b0;
    boundary();
    expect_status("R11 request dropped slot3", 2'd3, 16'h0000);
    expect_silent("R11 slot0 silent", 2'd0);
    boundary();
  endtask

  task automatic t_replace();
    send_cw(16'h2100);
    send_cw(16'h2800);
    expect_rb("R12 later request wins", 2'd3, 16'h28AA);
    boundary();
    send_cw(16'h2100);
    send_cw(16'h0000);
    expect_status("R12 later plain word cancels", 2'd3, 16'h0000);
    boundary();
  endtask

  task automatic ovr_step(input logic [3:0] v, input logic [15:0] exp, input string tag);
    ovr_in = v;
    boundary();
    expect_status(tag, 2'd3, exp);
  endtask

  task automatic t_ovr();
    send_cw(16'h8000);
    boundary();
    boundary();
    ovr_step(4'b0110, 16'h0006, "R13 live L2 R1");
    ovr_step(4'b0001, 16'h0001, "R13 live follows lower");
    send_cw(16'h0000);
    ovr_step(4'b0000, 16'h0000, "R14 first boundary still live");
    ovr_step(4'b0011, 16'h0003, "R13 sticky rises");
    ovr_step(4'b1001, 16'h000B, "R13 sticky per channel max");
    ovr_step(4'b0000, 16'h000B, "R13 sticky holds");
    send_cw(16'h8000);
    ovr_step(4'b0000, 16'h000B, "R14 clear delayed one boundary");
    ovr_step(4'b0000, 16'h0000, "R14 clear in effect");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_slot_filter();
    t_protect();
    t_mode1();
    t_double();
    t_lost();
    t_replace();
    t_ovr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule